// File: doc/BRIEF.md
# SD Card Block-Write Controller with Busy Signalling

This block is the card-side controller for single-block and multi-block write commands. The data path reports two events for each block. At the start of a block it gives the byte offset of the accumulated write position and the write-protect state of the target region. At the end of the block it gives the result of the data CRC check. From these events the controller decides whether the block is accepted, rejected, or silently ignored. It then answers on the DAT0 line with a CRC status token. After the token it holds the line low for as long as the write buffer is full.

Accepted blocks go into a small write buffer. A programming handshake drains that buffer: `prog_req` stays high while blocks are waiting, and each `prog_done` pulse retires one block. Any of the following poisons the rest of a multi-block command: a CRC failure, a misaligned start, or a write to a protected region. Every later block of that command is then ignored until a stop command arrives.

A status query returns the error flags and a ready flag. The query also clears the error flags. A deselect releases DAT0 at once, and any pending programming continues. A reselect brings back the busy indication if the buffer is still full.

Top module: `sd_blkwr_ctrl`

## Requirements
- R1: After reset, `dat0_oe` is 0, `ready_for_data` is 1, `prog_req` is 0, and a status read returns 4'b0001.
- R2: A block that passes CRC in an active, unpoisoned command is answered on DAT0, starting in the cycle after `blk_end`. The answer is five bits: start 0, status 0,1,0, end 1. The block is queued, and `prog_req` is 1 from the next cycle.
- R3: A block that fails CRC is answered with the frame 0,1,0,1,1 (status 101). Status bit 1 (CRC error) is set, and the block is not queued.
- R4: After a CRC failure in a multi-block command, later blocks get no token and are not queued, until a stop or a new write command.
- R5: If `misalign_ok` is 0 and `blk_offs` is nonzero at a block start, status bit 2 (address error) is set. That block and every later block of the command get no token and are not queued. If `misalign_ok` is 1, the same block is accepted.
- R6: A block whose `blk_wp` is 1 at its start sets status bit 3 (write-protect violation). It is ignored, with no token and no queueing, and the command is poisoned.
- R7: While selected, with no token in flight and the buffer holding BUF_DEPTH blocks, DAT0 is driven low (`dat0_oe`=1, `dat0_out`=0).
- R8: `ready_for_data` is 1 exactly when the buffer holds fewer than BUF_DEPTH blocks. Each `prog_done` pulse retires one queued block.
- R9: A pulse on `stat_rd` gives `stat_vld` one cycle later, with `stat_word` = {wp_viol, addr_err, crc_err, ready} as they stood in the read cycle. The error flags are then cleared. An error raised in the same cycle as the read survives it.
- R10: `sel_clr` releases DAT0 (`dat0_oe`=0) from the next cycle, while `prog_req` and `prog_done` keep draining the buffer.
- R11: `sel_set` while the buffer is still full makes DAT0 low again from the next cycle.
- R12: A single-block command ends after its one block, and later blocks are ignored. A stop ends a poisoned command, and blocks outside a command are ignored. A new command after the stop accepts blocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Pulse: a write command begins |
| wr_multi | input | 1 | With `wr_start`: 1 for multi-block, 0 for single-block |
| stop | input | 1 | Pulse: stop transmission, back to transfer state |
| blk_begin | input | 1 | Pulse: a block's data starts |
| blk_offs | input | BLK_LOG2 | Byte offset of the accumulated position within a block, valid with `blk_begin` |
| blk_wp | input | 1 | Target region is write-protected, valid with `blk_begin` |
| misalign_ok | input | 1 | Configuration: misaligned writes allowed |
| blk_end | input | 1 | Pulse: block fully received |
| blk_crc_ok | input | 1 | CRC result, valid with `blk_end` |
| prog_req | output | 1 | Buffer holds at least one block awaiting programming |
| prog_done | input | 1 | Pulse: one block has been programmed |
| sel_set | input | 1 | Pulse: card selected |
| sel_clr | input | 1 | Pulse: card deselected (wins over `sel_set`) |
| stat_rd | input | 1 | Pulse: status query |
| stat_vld | output | 1 | Status word valid |
| stat_word | output | 4 | {wp_viol, addr_err, crc_err, ready_for_data} |
| ready_for_data | output | 1 | Buffer can accept another block |
| dat0_oe | output | 1 | DAT0 driver enable |
| dat0_out | output | 1 | DAT0 driven value |

## Verification
The tightest collision is a status query that lands in the same cycle as the detection of a new error. A clear-on-read design could wipe that error before anyone sees it. The bench raises `stat_rd` together with a misaligned `blk_begin` in the same cycle. It expects the snapshot to show no error, and it expects the next query to report the address error. A second overlap is the busy indication meeting a token, and meeting select changes while programming is still pending. Both are judged bit by bit at DAT0 through the scoreboard's queued expectations.

// File: rtl/sd_blkwr_ctrl.sv
module sd_blkwr_ctrl #(
  parameter int BUF_DEPTH = 2,
  parameter int BLK_LOG2  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_start,
  input  logic                wr_multi,
  input  logic                stop,
  input  logic                blk_begin,
  input  logic [BLK_LOG2-1:0] blk_offs,
  input  logic                blk_wp,
  input  logic                misalign_ok,
  input  logic                blk_end,
  input  logic                blk_crc_ok,
  output logic                prog_req,
  input  logic                prog_done,
  input  logic                sel_set,
  input  logic                sel_clr,
  input  logic                stat_rd,
  output logic                stat_vld,
  output logic [3:0]          stat_word,
  output logic                ready_for_data,
  output logic                dat0_oe,
  output logic                dat0_out
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);

  logic             active, multi, poison, sel_q;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       tok_sr;
  logic [2:0]       tok_left;
  logic             crc_err, addr_err, wp_viol;

  logic live, full, bad_align, bad_wp, end_take, accept, crc_fail, pop;

  assign live      = active && !poison;
  assign full      = (cnt == FULL_CNT);
  assign bad_align = blk_begin && live && !misalign_ok && (blk_offs != '0);
  assign bad_wp    = blk_begin && live && blk_wp;
  assign end_take  = blk_end && live && !full;
  assign accept    = end_take && blk_crc_ok;
  assign crc_fail  = end_take && !blk_crc_ok;
  assign pop       = prog_done && (cnt != '0);

  assign prog_req       = (cnt != '0);
  assign ready_for_data = !full;
  assign dat0_oe        = sel_q && ((tok_left != '0) || full);
  assign dat0_out       = (tok_left != '0) ? tok_sr[4] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      multi  <= 1'b0;
      poison <= 1'b0;
    end else if (stop) begin
      active <= 1'b0;
      poison <= 1'b0;
    end else if (wr_start) begin
      active <= 1'b1;
      multi  <= wr_multi;
      poison <= 1'b0;
    end else begin
      if (bad_align || bad_wp || crc_fail) poison <= 1'b1;
      if (end_take && !multi) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(accept) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= 1'b1;
    else if (sel_clr) sel_q <= 1'b0;
    else if (sel_set) sel_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_sr   <= 5'b11111;
      tok_left <= '0;
    end else if (end_take) begin
      tok_sr   <= blk_crc_ok ? 5'b00101 : 5'b01011;
      tok_left <= 3'd5;
    end else if (tok_left != '0) begin
      tok_sr   <= {tok_sr[3:0], 1'b1};
      tok_left <= tok_left - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_err  <= 1'b0;
      addr_err <= 1'b0;
      wp_viol  <= 1'b0;
    end else begin
      crc_err  <= (crc_err  && !stat_rd) || crc_fail;
      addr_err <= (addr_err && !stat_rd) || bad_align;
      wp_viol  <= (wp_viol  && !stat_rd) || bad_wp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_vld  <= 1'b0;
      stat_word <= '0;
    end else begin
      stat_vld <= stat_rd;
      if (stat_rd) stat_word <= {wp_viol, addr_err, crc_err, !full};
    end
  end

  // R10
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_clr |=> !dat0_oe);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R4
  poison_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poison && blk_end && !stop && !wr_start) |=> (cnt <= $past(cnt)));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !blk_begin && !blk_end) |=> !(crc_err || addr_err || wp_viol));

  // R2
  prog_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> prog_req);

  // R8
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_for_data) |-> $past(accept));

endmodule

// File: tb/sd_blkwr_ctrl_tb_top.sv
module sd_blkwr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 0, wr_multi = 0, stop = 0, blk_begin = 0, blk_wp = 0;
  logic misalign_ok = 0, blk_end = 0, blk_crc_ok = 0, prog_done = 0;
  logic sel_set = 0, sel_clr = 0, stat_rd = 0;
  logic [8:0] blk_offs = '0;
  logic prog_req, stat_vld, ready_for_data, dat0_oe, dat0_out;
  logic [3:0] stat_word;

  int n_run = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  sd_blkwr_ctrl #(.BUF_DEPTH(2), .BLK_LOG2(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_multi(wr_multi),
    .stop(stop), .blk_begin(blk_begin), .blk_offs(blk_offs), .blk_wp(blk_wp),
    .misalign_ok(misalign_ok), .blk_end(blk_end), .blk_crc_ok(blk_crc_ok),
    .prog_req(prog_req), .prog_done(prog_done), .sel_set(sel_set),
    .sel_clr(sel_clr), .stat_rd(stat_rd), .stat_vld(stat_vld),
    .stat_word(stat_word), .ready_for_data(ready_for_data),
    .dat0_oe(dat0_oe), .dat0_out(dat0_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (stat_vld) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected status", int'(stat_word), 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(stat_word == e, "R9 status word", int'(stat_word), int'(e));
      end
    end
  end

  task automatic pulse_cmd(input int which, input bit m);
    @(negedge clk);
    case (which)
      0: begin wr_start = 1; wr_multi = m; end
      1: stop = 1;
      2: prog_done = 1;
      3: sel_clr = 1;
      default: sel_set = 1;
    endcase
    @(negedge clk);
    wr_start = 0; stop = 0; prog_done = 0; sel_clr = 0; sel_set = 0;
  endtask

  task automatic blk(input logic [8:0] offs, input bit wp, input bit ok);
    @(negedge clk); blk_offs = offs; blk_wp = wp; blk_begin = 1;
    @(negedge clk); blk_begin = 0; blk_wp = 0;
    @(negedge clk); blk_end = 1; blk_crc_ok = ok;
    @(negedge clk); blk_end = 0;
  endtask

  task automatic tok(input logic [2:0] st, input string req);
    logic [4:0] f;
    bit oe_ok;
    f = '0; oe_ok = 1;
    for (int i = 0; i < 5; i++) begin
      f = {f[3:0], dat0_out};
      if (!dat0_oe) oe_ok = 0;
      if (i < 4) @(negedge clk);
    end
    chk(oe_ok && f == {1'b0, st, 1'b1}, req, int'(f), int'({1'b0, st, 1'b1}));
  endtask

  task automatic quiet(input string req);
    bit q;
    q = 1;
    for (int i = 0; i < 6; i++) begin
      if (dat0_oe) q = 0;
      @(negedge clk);
    end
    chk(q, req, int'(!q), 0);
  endtask

  task automatic rd_stat(input logic [3:0] e);
    exp_q.push_back(e);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!dat0_oe && ready_for_data && !prog_req, "R1 reset outputs",
        int'({dat0_oe, ready_for_data, prog_req}), 3'b010);
    rd_stat(4'b0001);

    // R2 single block accepted, R12 single ends after one block
    pulse_cmd(0, 0);
    blk(9'd0, 0, 1);
    tok(3'b010, "R2 accept token");
    @(negedge clk);
    chk(prog_req && ready_for_data, "R2 queued", int'({prog_req, ready_for_data}), 3);
    blk(9'd0, 0, 1);
    quiet("R12 single-block ignores second block");
    pulse_cmd(2, 0);
    chk(!prog_req, "R8 prog_done retires", int'(prog_req), 0);

    // R7 busy when full, R10/R11 deselect and reselect
    pulse_cmd(0, 1);
    blk(9'd0, 0, 1);
    tok(3'b010, "R2 first multi token");
    blk(9'd0, 0, 1);
    tok(3'b010, "R2 second multi token");
    @(negedge clk);
    chk(dat0_oe && !dat0_out, "R7 busy low when full", int'({dat0_oe, dat0_out}), 2);
    chk(!ready_for_data, "R8 not ready when full", int'(ready_for_data), 0);
    rd_stat(4'b0000);
    pulse_cmd(3, 0);
    chk(!dat0_oe, "R10 deselect releases line", int'(dat0_oe), 0);
    pulse_cmd(4, 0);
    chk(dat0_oe && !dat0_out, "R11 reselect resumes busy", int'({dat0_oe, dat0_out}), 2);
    pulse_cmd(3, 0);
    pulse_cmd(2, 0);
    chk(ready_for_data && prog_req, "R10 programming continues deselected",
        int'({ready_for_data, prog_req}), 3);
    pulse_cmd(4, 0);
    chk(!dat0_oe, "R11 reselect not full no busy", int'(dat0_oe), 0);
    pulse_cmd(2, 0);
    pulse_cmd(1, 0);

    // R3 CRC failure, R4 poison
    pulse_cmd(0, 1);
    blk(9'd0, 0, 0);
    tok(3'b101, "R3 crc error token");
    @(negedge clk);
    chk(!prog_req, "R3 bad block not queued", int'(prog_req), 0);
    blk(9'd0, 0, 1);
    quiet("R4 poisoned block no token");
    chk(!prog_req, "R4 poisoned block not queued", int'(prog_req), 0);
    rd_stat(4'b0011);
    rd_stat(4'b0001);
    pulse_cmd(1, 0);
    blk(9'd0, 0, 1);
    quiet("R12 block outside command ignored");
    pulse_cmd(0, 1);
    blk(9'd0, 0, 1);
    tok(3'b010, "R12 new command accepts after stop");
    pulse_cmd(2, 0);
    pulse_cmd(1, 0);

    // R5 misalignment
    misalign_ok = 0;
    pulse_cmd(0, 1);
    blk(9'd4, 0, 1);
    quiet("R5 misaligned block no token");
    blk(9'd0, 0, 1);
    quiet("R5 rest ignored");
    chk(!prog_req, "R5 nothing queued", int'(prog_req), 0);
    rd_stat(4'b0101);
    pulse_cmd(1, 0);
    misalign_ok = 1;
    pulse_cmd(0, 1);
    blk(9'd4, 0, 1);
    tok(3'b010, "R5 misalign allowed accepted");
    pulse_cmd(2, 0);
    pulse_cmd(1, 0);

    // R6 write protect
    pulse_cmd(0, 1);
    blk(9'd0, 1, 1);
    quiet("R6 protected block no token");
    chk(!prog_req, "R6 not queued", int'(prog_req), 0);
    rd_stat(4'b1001);
    pulse_cmd(1, 0);

    // R9 read and error in same cycle
    misalign_ok = 0;
    pulse_cmd(0, 1);
    exp_q.push_back(4'b0001);
    @(negedge clk); blk_offs = 9'd8; blk_begin = 1; stat_rd = 1;
    @(negedge clk); blk_begin = 0; stat_rd = 0;
    @(negedge clk);
    rd_stat(4'b0101);
    pulse_cmd(1, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all status reads seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule